// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block is a centralized barrier for a group of processors. It can be used for any number of barrier episodes in a row. Before it arrives at a barrier, each processor flips its own local sense bit. It then pulses its arrival line and presents that new sense on the same cycle. The unit counts each arrival once.

When the last participant of an episode has been counted, the unit clears its count and its record of arrivals. It then drives the shared release bit to the sense carried by that episode. A processor waits until the release bit equals its own local sense, and then it proceeds.

Release follows the episode's sense and not a fixed level. A fast processor that comes back for the next episode cannot overwrite release. It therefore cannot strand a slower processor that has not yet seen the previous release.

A parameter selects the counting structure. In flat mode, every arrival is added straight into one central counter. In paired mode, neighbouring processors first meet at a two-input barrier. Only one representative per completed pair reaches the central counter, which then counts to half the participant number. Both modes show the same timing at the ports.

Top module: `sense_barrier`

## Requirements
- R1: After reset, release_o is 0, waiting_o is all zeros and dup_err_o is all zeros.
- R2: When processor i arrives (arrive_i[i]=1) and has not yet arrived in the current episode, waiting_o[i] becomes 1 on the following cycle, unless that arrival completes the episode.
- R3: Arrivals from several processors in the same cycle are all counted in that cycle; a population-count adder combines them.
- R4: On the cycle after the arrival that brings the count to NPROC, waiting_o clears to all zeros and release_o takes the sense_i value of the lowest-index processor that arrived in that completing cycle.
- R5: release_o changes only on episode completion; arrivals that do not complete an episode leave it unchanged.
- R6: An arrival from a processor whose waiting_o bit is already 1 is not counted, leaves waiting_o unchanged, and sets that processor's bit in dup_err_o for exactly the following cycle.
- R7: The barrier is reusable. Episodes whose arrivals carry alternating senses 1, 0, 1, ... drive release_o to 1, 0, 1, ... in turn, with no reset between them.
- R8: With PAIRED=1 and NPROC even, processors 2k and 2k+1 form a pair. Only the completion of a pair sends one increment to the central counter, which counts to NPROC/2. The port behaviour matches flat mode cycle for cycle.
- R9: NPROC is a parameter of at least 2 (default 8). PAIRED=0 selects flat counting. An odd NPROC always uses flat counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arrive_i | input | NPROC | One-cycle arrival pulse per processor |
| sense_i | input | NPROC | Local sense of each processor, valid with its arrival |
| release_o | output | 1 | Shared release bit; a processor proceeds when it equals its local sense |
| waiting_o | output | NPROC | Processors counted in the current, unfinished episode |
| dup_err_o | output | NPROC | One-cycle flag for an arrival rejected as a repeat within the episode |

## Verification
Several properties are checked by assertions on every cycle:
- release_o moves only in the cycle after every processor was waiting or arriving (R5).
- Such a cycle always clears waiting_o (R4).
- The waiting set otherwise only grows (R2).
- dup_err_o never flags a processor that was not already waiting (R6).
- A completing cycle whose arrivals all carry one sense leaves release_o at that sense.

Only the bench's scenarios can show the rest:
- Simultaneous and staggered arrival patterns count correctly (R3).
- The lowest-index arriving processor selects the sense when completing arrivals disagree (R4).
- Many episodes in a row alternate release_o (R7).
- Flat and paired counting produce identical port traces for the same stimulus (R8).

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic {
    SB_FLAT   = 1'b0,
    SB_PAIRED = 1'b1
  } sb_topo_e;

  // Width needed to hold values 0..n
  function automatic int unsigned sb_cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sb_popcount.sv
module sb_popcount #(
  parameter int unsigned W  = 8,
  parameter int unsigned OW = sb_pkg::sb_cnt_w(W)
) (
  input  logic [W-1:0]  bits_i,
  output logic [OW-1:0] count_o
);

  // R3: every set bit of the cycle contributes to the sum
  always_comb begin
    count_o = '0;
    for (int unsigned i = 0; i < W; i++) begin
      count_o = count_o + OW'(bits_i[i]);
    end
  end

endmodule

// File: rtl/sb_pair_stage.sv
module sb_pair_stage #(
  parameter int unsigned NPAIR = 4
) (
  input  logic [2*NPAIR-1:0] accept_i,
  input  logic [2*NPAIR-1:0] held_i,
  output logic [NPAIR-1:0]   rep_o
);

  // R8: a pair completes when both members are in and at least one
  // of them is new this cycle; that completion is a single increment.
  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic lo_in;
    logic hi_in;
    logic fresh;
    assign lo_in    = accept_i[2*k]   | held_i[2*k];
    assign hi_in    = accept_i[2*k+1] | held_i[2*k+1];
    assign fresh    = accept_i[2*k]   | accept_i[2*k+1];
    assign rep_o[k] = lo_in & hi_in & fresh;
  end

endmodule

// File: rtl/sb_root_counter.sv
module sb_root_counter #(
  parameter int unsigned TOTAL = 8,
  parameter int unsigned CW    = sb_pkg::sb_cnt_w(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] inc_i,
  output logic          complete_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   sum;
  logic          cnt_en;

  always_comb begin
    sum        = {1'b0, cnt_q} + {1'b0, inc_i};
    complete_o = (sum == (CW+1)'(TOTAL));
    cnt_en     = (inc_i != '0);
    cnt_d      = complete_o ? '0 : sum[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sb_sense_pick.sv
module sb_sense_pick #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] accept_i,
  input  logic [W-1:0] sense_i,
  output logic         sense_o
);

  // R4: lowest-index accepted arrival wins; scan downwards so it is
  // the last assignment to take effect
  always_comb begin
    sense_o = 1'b0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (accept_i[i]) begin
        sense_o = sense_i[i];
      end
    end
  end

endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int unsigned NPROC  = 8,
  parameter bit          PAIRED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] arrive_i,
  input  logic [NPROC-1:0] sense_i,
  output logic             release_o,
  output logic [NPROC-1:0] waiting_o,
  output logic [NPROC-1:0] dup_err_o
);

  import sb_pkg::*;

  localparam sb_topo_e    TOPO  = (PAIRED && (NPROC % 2 == 0)) ? SB_PAIRED : SB_FLAT;
  localparam int unsigned RW    = (TOPO == SB_PAIRED) ? NPROC / 2 : NPROC;
  localparam int unsigned CW    = sb_cnt_w(RW);

  logic [NPROC-1:0] held_q, held_d;
  logic [NPROC-1:0] dup_q, dup_d;
  logic             rel_q, rel_d;
  logic             rel_en;

  logic [NPROC-1:0] accept;
  logic [RW-1:0]    rep;
  logic [CW-1:0]    rep_cnt;
  logic             complete;
  logic             ep_sense;

  // Filter repeats (R6)
  assign accept = arrive_i & ~held_q;

  // R8/R9: structure chosen by parameter
  if (TOPO == SB_PAIRED) begin : g_paired
    sb_pair_stage #(.NPAIR(RW)) u_pairs (
      .accept_i (accept),
      .held_i   (held_q),
      .rep_o    (rep)
    );
  end else begin : g_flat
    assign rep = accept;
  end

  sb_popcount #(.W(RW), .OW(CW)) u_popc (
    .bits_i  (rep),
    .count_o (rep_cnt)
  );

  sb_root_counter #(.TOTAL(RW), .CW(CW)) u_root (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (rep_cnt),
    .complete_o (complete)
  );

  sb_sense_pick #(.W(NPROC)) u_pick (
    .accept_i (accept),
    .sense_i  (sense_i),
    .sense_o  (ep_sense)
  );

  // Next-state
  always_comb begin
    dup_d  = arrive_i & held_q;
    held_d = complete ? '0 : (held_q | accept);
    rel_en = complete;
    rel_d  = ep_sense;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      dup_q  <= '0;
    end else begin
      held_q <= held_d;
      dup_q  <= dup_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
    end else if (rel_en) begin
      rel_q <= rel_d;
    end
  end

  assign release_o = rel_q;
  assign waiting_o = held_q;
  assign dup_err_o = dup_q;

endmodule

// File: rtl/sb_barrier_chk.sv
module sb_barrier_chk #(
  parameter int unsigned NPROC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] arrive_i,
  input logic [NPROC-1:0] sense_i,
  input logic             release_o,
  input logic [NPROC-1:0] waiting_o,
  input logic [NPROC-1:0] dup_err_o
);

  logic             all_in;
  logic [NPROC-1:0] fresh;
  assign all_in = &(waiting_o | arrive_i);
  assign fresh  = arrive_i & ~waiting_o;

  assert_release_only_on_completion_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (release_o != $past(release_o)) |-> $past(all_in));

  assert_completion_clears_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    $past(all_in) |-> (waiting_o == '0));

  assert_waiting_grows_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    !$past(all_in) |-> ((waiting_o & $past(waiting_o)) == $past(waiting_o)));

  assert_dup_only_if_waiting_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    ((dup_err_o & ~$past(waiting_o)) == '0));

  assert_release_high_sense_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (all_in && fresh != '0 && (fresh & ~sense_i) == '0) |=> release_o);

  assert_release_low_sense_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (all_in && fresh != '0 && (fresh & sense_i) == '0) |=> !release_o);

endmodule

bind sense_barrier sb_barrier_chk #(.NPROC(NPROC)) u_chk (.*);

// File: tb/sense_barrier_tb_top.sv
module sense_barrier_tb_top;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] arrive;
  logic [N-1:0] sense;

  logic         rel_f, rel_t;
  logic [N-1:0] wait_f, wait_t, dup_f, dup_t;

  int checks;
  int errors;
  string cur_req;

  // reference model state
  logic [N-1:0] m_wait;
  logic [N-1:0] m_dup;
  logic         m_rel;

  sense_barrier #(.NPROC(N), .PAIRED(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive), .sense_i(sense),
    .release_o(rel_f), .waiting_o(wait_f), .dup_err_o(dup_f)
  );

  sense_barrier #(.NPROC(N), .PAIRED(1'b1)) dut_tree_i (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive), .sense_i(sense),
    .release_o(rel_t), .waiting_o(wait_t), .dup_err_o(dup_t)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("flat release", {{(N-1){1'b0}}, rel_f}, {{(N-1){1'b0}}, m_rel});
    chk("flat waiting", wait_f, m_wait);
    chk("flat dup", dup_f, m_dup);
    chk("R8 paired release", {{(N-1){1'b0}}, rel_t}, {{(N-1){1'b0}}, m_rel});
    chk("R8 paired waiting", wait_t, m_wait);
    chk("R8 paired dup", dup_t, m_dup);
  endtask

  // one clock: drive at negedge, model, compare at next negedge
  task automatic cyc(input logic [N-1:0] a, input logic [N-1:0] s);
    logic [N-1:0] acc;
    logic [N-1:0] all;
    logic         pick;
    bit           found;
    arrive = a;
    sense  = s;
    acc    = a & ~m_wait;
    all    = m_wait | acc;
    m_dup  = a & m_wait;
    if (acc != '0 && &all) begin
      found = 0;
      pick  = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (!found && acc[i]) begin
          pick  = s[i];
          found = 1;
        end
      end
      m_rel  = pick;
      m_wait = '0;
    end else begin
      m_wait = all;
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ep;
    checks = 0;
    errors = 0;
    arrive = '0;
    sense  = '0;
    rst_n  = 1'b0;
    m_wait = '0;
    m_dup  = '0;
    m_rel  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    compare_all();

    // episode 1, sense 1
    cur_req = "R2";
    cyc(8'b0000_0001, 8'hFF);
    cur_req = "R3";
    cyc(8'b0001_1100, 8'hFF);
    cur_req = "R6";
    cyc(8'b0000_0001, 8'hFF);
    cur_req = "R5";
    cyc(8'b0000_0000, 8'h00);
    chk("R5 release held low", {7'b0, rel_f}, 8'h00);
    cur_req = "R4";
    cyc(8'b1110_0010, 8'hFF);
    chk("R4 release set to 1", {7'b0, rel_f}, 8'h01);
    chk("R4 waiting cleared", wait_f, 8'h00);

    // episode 2, sense 0, staggered
    cur_req = "R7";
    for (int i = 0; i < N; i++) begin
      cyc(8'(1 << i), 8'h00);
    end
    chk("R7 release back to 0", {7'b0, rel_f}, 8'h00);

    // episode 3: completing arrivals disagree, lowest index has sense 1
    cur_req = "R4";
    cyc(8'b0000_1111, 8'hFF);
    cyc(8'b1111_0000, 8'b0101_0000);
    chk("R4 lowest-index sense picked", {7'b0, rel_f}, 8'h01);

    // episode 4: one pair completes together in the same cycle
    cur_req = "R8";
    cyc(8'b0000_1100, 8'h00);
    cyc(8'b0000_0001, 8'h00);
    cyc(8'b1111_0010, 8'h00);
    chk("R8 paired release 0", {7'b0, rel_t}, 8'h00);

    // R9: every processor arrives at once
    cur_req = "R9";
    cyc(8'hFF, 8'hFF);
    chk("R9 full-width single-cycle episode", {7'b0, rel_f}, 8'h01);
    cyc(8'h00, 8'h00);

    // many random episodes with repeats
    cur_req = "R7";
    ep = 1'b1;
    for (int e = 0; e < 300; e++) begin
      int slot[N];
      ep = ~ep;
      for (int i = 0; i < N; i++) slot[i] = int'($urandom_range(0, 5));
      for (int t = 0; t < 6; t++) begin
        logic [N-1:0] a;
        logic [N-1:0] s;
        a = '0;
        s = 8'($urandom);
        for (int i = 0; i < N; i++) begin
          if (slot[i] == t) begin
            a[i] = 1'b1;
            s[i] = ep;
          end else if (slot[i] < t && $urandom_range(0, 7) == 0) begin
            a[i] = 1'b1;
            s[i] = ep;
          end
        end
        cyc(a, s);
      end
      chk("R7 release follows episode sense", {7'b0, rel_f}, {7'b0, ep});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule